// File: doc/BRIEF.md
# Receive FIFO Data Request Gate

This block holds received frame bytes in a byte-wide FIFO and decides when the host should be asked to read them. The receive MAC pushes bytes into the write side. With each byte it also gives a marker for the first byte after the start frame delimiter and a marker for the last byte of the frame. The host watches a single request line and pulses a read strobe. Each read returns a byte together with a data-valid flag that says whether the read was honoured.

The request rises in one of three cases. In normal mode it rises when the FIFO holds 64 bytes. In the early (low-latency) mode it rises when the frame now arriving has delivered more than 12 bytes past its start frame delimiter. In either mode it rises when a frame's last byte is sitting in the FIFO, so short frames can drain. Once raised, the request stays high in burst fashion for as long as at least one byte can still be read. A read made while the request is low is refused: data-valid stays low and the FIFO does not move.

Top module: `rxq_rx_drq`

## Requirements
- R1: After reset the request output is low, data-valid is low and the FIFO is empty.
- R2: With the mode input at 0 (normal), and with no frame end buffered, the request is low while 63 bytes are held. It is high in the cycle after the write edge that stores the 64th byte.
- R3: With the mode input at 1 (early), the request is low after 12 bytes of the current frame have been written. It is high in the cycle after the write edge of that frame's 13th byte, even though far fewer than 64 bytes are held.
- R4: Once high, the request stays high while the FIFO holds at least one byte, even below every threshold. It falls in the cycle after the read that empties the FIFO.
- R5: A read strobe sampled while the request is high is accepted. In the next cycle data-valid is high and the data output carries the oldest byte, so bytes leave in write order.
- R6: A read strobe sampled while the request is low leaves data-valid low in the next cycle and does not advance the FIFO. The next accepted read returns the byte that was at the head.
- R7: While a byte written with the last-byte marker is still in the FIFO, the request is high whatever the mode and fill level.
- R8: A write carrying the first-byte marker restarts the early-mode byte count at 1. After a new frame starts, the request in early mode waits for that frame's own 13th byte.
- R9: A write offered while 128 bytes are held is dropped. The level stays at 128, and the dropped byte never appears on the read side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mac_wr_en | input | 1 | Write strobe from the receive MAC |
| mac_wr_byte | input | 8 | Byte to store |
| mac_wr_first | input | 1 | Marks the first byte after the start frame delimiter |
| mac_wr_last | input | 1 | Marks the last byte of the frame |
| early_rcv | input | 1 | 1 selects the early request threshold, 0 the fill threshold |
| host_rd | input | 1 | Host read strobe |
| host_byte | output | 8 | Byte returned by the last accepted read |
| host_valid | output | 1 | High for one cycle after an accepted read |
| host_req | output | 1 | Receive data request to the host |

## Verification
The hardest state to reach from the ports is the request being held high purely by the burst hold: the FIFO is below both thresholds and no frame end is buffered. The bench gets there by crossing a threshold and then draining with reads, checking the request before each read down to the last byte. The refused-read case with data present but below threshold comes from starting a new frame in early mode and reading before its 13th byte. A later accepted read must then return that frame's first byte.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int unsigned RXQ_DW = 8;

  typedef struct packed {
    logic              last;
    logic [RXQ_DW-1:0] data;
  } rxq_entry_t;

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [RXQ_DW-1:0] wr_data,
  input  logic              wr_last,
  input  logic              rd_acc,
  output logic              wr_taken,
  output rxq_entry_t        head,
  output logic [LW-1:0]     level
);

  rxq_entry_t      mem [DEPTH];
  logic [AW-1:0]   wptr_q, rptr_q;
  logic [LW-1:0]   level_q;
  logic            full;

  function automatic logic [LW-1:0] level_step(input logic [LW-1:0] cur,
                                               input logic up, input logic down);
    logic [LW-1:0] r;
    r = cur;
    if (up && !down)      r = cur + 1'b1;
    else if (down && !up) r = cur - 1'b1;
    return r;
  endfunction

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (level_q == LW'(DEPTH));
  assign wr_taken = wr_req && !full;
  assign head     = mem[rptr_q];
  assign level    = level_q;

  always_ff @(posedge clk) begin
    if (wr_taken) begin
      mem[wptr_q] <= '{last: wr_last, data: wr_data};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (wr_taken) wptr_q <= ptr_inc(wptr_q);
      if (rd_acc)   rptr_q <= ptr_inc(rptr_q);
      level_q <= level_step(level_q, wr_taken, rd_acc);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req && !rd_acc) |=> (level_q == LW'(DEPTH))); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |-> (level_q != '0)); // R6

endmodule

// File: rtl/rxq_frame_track.sv
module rxq_frame_track #(
  parameter int unsigned FB_W = 11,
  parameter int unsigned LW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_taken,
  input  logic            wr_first,
  input  logic            wr_last,
  input  logic            rd_acc,
  input  logic            rd_last,
  output logic [FB_W-1:0] frame_bytes,
  output logic [LW-1:0]   ends_held
);

  logic [FB_W-1:0] fb_q;
  logic [LW-1:0]   ends_q;
  logic            end_in, end_out;

  function automatic logic [FB_W-1:0] fb_next(input logic [FB_W-1:0] cur,
                                              input logic take, input logic first);
    if (!take)                 return cur;
    if (first)                 return FB_W'(1);
    if (cur == {FB_W{1'b1}})   return cur;
    return cur + 1'b1;
  endfunction

  assign end_in  = wr_taken && wr_last;
  assign end_out = rd_acc && rd_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fb_q   <= '0;
      ends_q <= '0;
    end else begin
      fb_q <= fb_next(fb_q, wr_taken, wr_first);
      if (end_in && !end_out)      ends_q <= ends_q + 1'b1;
      else if (end_out && !end_in) ends_q <= ends_q - 1'b1;
    end
  end

  assign frame_bytes = fb_q;
  assign ends_held   = ends_q;

  AST_FIRST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_taken && wr_first) |=> (fb_q == FB_W'(1))); // R8

endmodule

// File: rtl/rxq_req_ctrl.sv
module rxq_req_ctrl
  import rxq_pkg::*;
#(
  parameter int unsigned LW       = 8,
  parameter int unsigned FB_W     = 11,
  parameter int unsigned NORM_TH  = 64,
  parameter int unsigned EARLY_TH = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LW-1:0]     level,
  input  logic [FB_W-1:0]   frame_bytes,
  input  logic [LW-1:0]     ends_held,
  input  logic              early,
  input  logic              rd_stb,
  input  rxq_entry_t        head,
  output logic              rd_acc,
  output logic              req,
  output logic              valid,
  output logic [RXQ_DW-1:0] rd_byte
);

  logic              hold_q, valid_q;
  logic [RXQ_DW-1:0] byte_q;
  logic              hit_fill, hit_early, hit_end, trigger, nonempty;

  function automatic logic fill_reached(input logic [LW-1:0] lv);
    return lv >= LW'(NORM_TH);
  endfunction

  function automatic logic early_reached(input logic [FB_W-1:0] fb);
    return fb > FB_W'(EARLY_TH);
  endfunction

  assign hit_fill  = fill_reached(level);
  assign hit_early = early && early_reached(frame_bytes);
  assign hit_end   = (ends_held != '0);
  assign trigger   = hit_fill || hit_early || hit_end;
  assign nonempty  = (level != '0);
  assign req       = (trigger || hold_q) && nonempty;
  assign rd_acc    = rd_stb && req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= 1'b0;
      valid_q <= 1'b0;
      byte_q  <= '0;
    end else begin
      hold_q  <= req;
      valid_q <= rd_acc;
      if (rd_acc) byte_q <= head.data;
    end
  end

  assign valid   = valid_q;
  assign rd_byte = byte_q;

  AST_HOLD_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !(rd_stb && level == LW'(1))) |=> req); // R4
  AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(rd_stb && req)); // R5
  AST_REFUSED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !req) |=> !valid); // R6
  AST_END_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ends_held != '0) |-> req); // R7

endmodule

// File: rtl/rxq_rx_drq.sv
module rxq_rx_drq
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH    = 128,
  parameter int unsigned NORM_TH  = 64,
  parameter int unsigned EARLY_TH = 12,
  parameter int unsigned FB_W     = 11,
  localparam int unsigned LW = $clog2(DEPTH) + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mac_wr_en,
  input  logic [7:0] mac_wr_byte,
  input  logic       mac_wr_first,
  input  logic       mac_wr_last,
  input  logic       early_rcv,
  input  logic       host_rd,
  output logic [7:0] host_byte,
  output logic       host_valid,
  output logic       host_req
);

  logic            wr_taken, rd_acc;
  rxq_entry_t      head;
  logic [LW-1:0]   level, ends_held;
  logic [FB_W-1:0] frame_bytes;

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_req(mac_wr_en), .wr_data(mac_wr_byte), .wr_last(mac_wr_last),
    .rd_acc(rd_acc), .wr_taken(wr_taken), .head(head), .level(level)
  );

  rxq_frame_track #(.FB_W(FB_W), .LW(LW)) u_track (
    .clk(clk), .rst_n(rst_n),
    .wr_taken(wr_taken), .wr_first(mac_wr_first), .wr_last(mac_wr_last),
    .rd_acc(rd_acc), .rd_last(head.last),
    .frame_bytes(frame_bytes), .ends_held(ends_held)
  );

  rxq_req_ctrl #(.LW(LW), .FB_W(FB_W), .NORM_TH(NORM_TH), .EARLY_TH(EARLY_TH)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .level(level), .frame_bytes(frame_bytes), .ends_held(ends_held),
    .early(early_rcv), .rd_stb(host_rd), .head(head),
    .rd_acc(rd_acc), .req(host_req), .valid(host_valid), .rd_byte(host_byte)
  );

  AST_FILL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (level >= LW'(NORM_TH)) |-> host_req); // R2
  AST_EARLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (early_rcv && frame_bytes > FB_W'(EARLY_TH) && level != '0) |-> host_req); // R3
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> !host_req); // R4

endmodule

// File: tb/tb_rxq_rx_drq.sv
module tb_rxq_rx_drq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mac_wr_en = 1'b0;
  logic [7:0] mac_wr_byte = '0;
  logic       mac_wr_first = 1'b0;
  logic       mac_wr_last = 1'b0;
  logic       early_rcv = 1'b0;
  logic       host_rd = 1'b0;
  logic [7:0] host_byte;
  logic       host_valid;
  logic       host_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rxq_rx_drq dut (
    .clk(clk), .rst_n(rst_n),
    .mac_wr_en(mac_wr_en), .mac_wr_byte(mac_wr_byte),
    .mac_wr_first(mac_wr_first), .mac_wr_last(mac_wr_last),
    .early_rcv(early_rcv), .host_rd(host_rd),
    .host_byte(host_byte), .host_valid(host_valid), .host_req(host_req)
  );

  task automatic chk(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic push(input logic [7:0] b, input logic first, input logic last);
    @(negedge clk);
    mac_wr_en = 1'b1; mac_wr_byte = b; mac_wr_first = first; mac_wr_last = last;
    @(negedge clk);
    mac_wr_en = 1'b0; mac_wr_first = 1'b0; mac_wr_last = 1'b0;
  endtask

  task automatic pop(input string req, input bit exp_valid, input logic [7:0] exp_byte);
    @(negedge clk);
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    chk(req, int'(host_valid), int'(exp_valid));
    if (exp_valid) chk(req, int'(host_byte), int'(exp_byte));
  endtask

  task automatic t_reset();
    chk("R1 req", int'(host_req), 0);
    chk("R1 valid", int'(host_valid), 0);
    pop("R1 R6 empty read", 1'b0, 8'h00);
    chk("R1 still empty", int'(host_req), 0);
  endtask

  task automatic t_normal();
    early_rcv = 1'b0;
    for (int i = 0; i < 63; i++) push(8'(i + 8'h10), i == 0, 1'b0);
    chk("R2 63 held", int'(host_req), 0);
    push(8'(63 + 8'h10), 1'b0, 1'b0);
    chk("R2 64 held", int'(host_req), 1);
    for (int i = 0; i < 64; i++) begin
      chk("R4 hold", int'(host_req), 1);
      pop("R5 order", 1'b1, 8'(i + 8'h10));
    end
    chk("R4 drop empty", int'(host_req), 0);
  endtask

  task automatic t_early();
    early_rcv = 1'b1;
    for (int i = 0; i < 12; i++) push(8'(i + 8'h80), i == 0, 1'b0);
    chk("R3 12 bytes", int'(host_req), 0);
    push(8'(12 + 8'h80), 1'b0, 1'b0);
    chk("R3 13 bytes", int'(host_req), 1);
    for (int i = 0; i < 13; i++) pop("R3 drain", 1'b1, 8'(i + 8'h80));
    chk("R4 early empty", int'(host_req), 0);
    pop("R6 empty after drain", 1'b0, 8'h00);
  endtask

  task automatic t_new_frame();
    early_rcv = 1'b1;
    for (int i = 0; i < 5; i++) push(8'(i + 8'h40), i == 0, 1'b0);
    chk("R8 restart count", int'(host_req), 0);
    pop("R6 refused with data", 1'b0, 8'h00);
    for (int i = 5; i < 13; i++) push(8'(i + 8'h40), 1'b0, 1'b0);
    chk("R8 own 13th", int'(host_req), 1);
    pop("R6 head kept", 1'b1, 8'h40);
    for (int i = 1; i < 13; i++) pop("R5 new frame", 1'b1, 8'(i + 8'h40));
    chk("R4 new frame empty", int'(host_req), 0);
  endtask

  task automatic t_frame_end();
    early_rcv = 1'b0;
    push(8'hA1, 1'b1, 1'b0);
    push(8'hA2, 1'b0, 1'b0);
    chk("R7 before end", int'(host_req), 0);
    push(8'hA3, 1'b0, 1'b1);
    chk("R7 end held", int'(host_req), 1);
    pop("R7 drain", 1'b1, 8'hA1);
    pop("R7 drain", 1'b1, 8'hA2);
    chk("R7 last still held", int'(host_req), 1);
    pop("R7 drain", 1'b1, 8'hA3);
    chk("R7 after drain", int'(host_req), 0);
  endtask

  task automatic t_full();
    early_rcv = 1'b0;
    for (int i = 0; i < 130; i++) push(8'(i), i == 0, 1'b0);
    chk("R9 full req", int'(host_req), 1);
    for (int i = 0; i < 128; i++) pop("R9 kept bytes", 1'b1, 8'(i));
    chk("R9 dropped gone", int'(host_req), 0);
    pop("R9 nothing extra", 1'b0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_early();
    t_new_frame();
    t_frame_end();
    t_full();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule